// File: doc/BRIEF.md
# Operand Memory Access Sequencer

This block drives the closing bus cycles of an 8-bit processor instruction once another stage has worked out the effective address. It receives a one-cycle start strobe together with the address, the kind of access, whether the address is a zero-page one, which processor model is being imitated (the original NMOS part or the later CMOS variant), and whether the instruction is a decimal-mode add or subtract. It then steps through the reads, stall cycles and writes that the access needs. Each step puts the address, the read/write direction and the write data on the bus for one clock.

The block does no decoding, no address arithmetic and no data arithmetic. A read-modify-write takes its new value from the `mod_data` input in the cycle the final write is driven, so the arithmetic unit can work on the captured operand in the meantime. The block also marks the one cycle in which the surrounding core should sample its interrupt lines. That cycle is always the final bus cycle of the operation. A single-cycle no-op on the CMOS model finishes at once and makes no data access.

Top module: `opmem_seq`

## Requirements
- R1: While `rst` is high, and in every cycle after reset until a start is accepted, `bus_act`, `bus_wr`, `done` and `irq_sample` are 0 and `bus_dout` is 0.
- R2: A start with `op_kind` = 0 (read) leads, in the next cycle, to one bus cycle with `bus_act`=1, `bus_wr`=0 at the effective address, with `done`=1 in that cycle. `bus_dout` is 0 whenever `bus_wr` is 0.
- R3: A start with `op_kind` = 1 (write) leads, in the next cycle, to a single write cycle (`bus_act`=1, `bus_wr`=1) carrying the current `mod_data`, with `done`=1.
- R4: A start with `op_kind` = 2 (read-modify-write) leads to a read, then a stall cycle, then a write of the current `mod_data`, on three consecutive cycles at the same address. `done`=1 only on the write.
- R5: With `cmos_sel`=0 latched, the stall cycle of a read-modify-write is a write of the byte on `bus_din` at the end of the first read cycle.
- R6: With `cmos_sel`=1 latched, the stall cycle of a read-modify-write is a second read (`bus_wr`=0) at the same address.
- R7: A read with `cmos_sel`=1 and `dec_mode`=1 takes two read cycles at the same address, with `done` on the second. With `cmos_sel`=0, `dec_mode` has no effect. `dec_mode` has no effect on write and read-modify-write.
- R8: With `zp_sel`=1, the upper 8 bits of `bus_addr` are 0x00 and the low 8 bits come from `eff_addr`. With `zp_sel`=0, all 16 bits come from `eff_addr`.
- R9: `irq_sample` is 1 exactly in the final bus cycle of each operation (the cycle with `done`=1 and `bus_act`=1) and 0 in every other cycle.
- R10: `op_kind` = 3 (fast no-op) with `cmos_sel`=1 gives `done`=1 in the next cycle with `bus_act`=0 and `irq_sample`=0. With `cmos_sel`=0, kind 3 behaves exactly as a read (R2, R7).
- R11: A start is accepted only in a cycle in which no operation is in progress, including its done cycle. A start at any other time has no effect.
- R12: Address, kind, zero-page, model and decimal inputs are sampled only in the cycle a start is accepted. Changing them later has no effect on the operation in progress. `mod_data` is taken live in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_kind | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 fast no-op |
| zp_sel | input | 1 | Effective address is a zero-page address |
| cmos_sel | input | 1 | 1 selects the CMOS model, 0 the original model |
| dec_mode | input | 1 | Instruction is a decimal-mode add or subtract |
| eff_addr | input | 16 | Effective address |
| mod_data | input | 8 | Value to store in a write cycle |
| bus_din | input | 8 | Data returned by the bus on reads |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 8 | Bus write data (0 when not writing) |
| bus_act | output | 1 | A bus cycle is driven this clock |
| bus_wr | output | 1 | The bus cycle is a write |
| done | output | 1 | Last cycle of the operation |
| irq_sample | output | 1 | Sample interrupt lines in this cycle |

## Verification
The hardest case to reach is the original-model stall write. Its data must be the byte the bus returned at the end of the first read, and the bus data changes on every cycle. The bench drives fresh random `bus_din` and `mod_data` on every cycle. It records the byte present at the capture edge and expects exactly that byte one cycle later. The cycle-by-cycle reference also scrambles every latched input and drives stray start pulses while an operation is busy, so that ignored starts and late input changes would show up at the ports. It first walks all 32 combinations of kind, model, decimal flag and zero-page flag, then runs random operations.

// File: rtl/opmem_pkg.sv
package opmem_pkg;
   localparam logic [1:0] K_RD  = 2'd0;
   localparam logic [1:0] K_WR  = 2'd1;
   localparam logic [1:0] K_RMW = 2'd2;
   localparam logic [1:0] K_NOP = 2'd3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD1,
      PH_RD2,
      PH_STALL,
      PH_WR,
      PH_NOP
   } phase_t;
endpackage

// File: rtl/opmem_ctrl.sv
module opmem_ctrl
   import opmem_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [1:0] op_kind,
   input  logic       cmos_sel,
   input  logic       dec_mode,
   output phase_t     phase_o,
   output logic       accept_o,
   output logic       cmos_o,
   output logic       act_o,
   output logic       wr_o,
   output logic       done_o,
   output logic       irq_o
);
   phase_t     phase_q, phase_d;
   logic [1:0] kind_q;
   logic       cmos_q;
   logic       dec_q;
   logic       two_reads;

   assign accept_o  = start && (phase_q == PH_IDLE);
   assign two_reads = cmos_q && dec_q && (kind_q != K_RMW);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               unique case (op_kind)
                  K_WR:    phase_d = PH_WR;
                  K_NOP:   phase_d = cmos_sel ? PH_NOP : PH_RD1;
                  default: phase_d = PH_RD1;
               endcase
            end
         end
         PH_RD1: begin
            if (kind_q == K_RMW)  phase_d = PH_STALL;
            else if (two_reads)   phase_d = PH_RD2;
            else                  phase_d = PH_IDLE;
         end
         PH_STALL: phase_d = PH_WR;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         kind_q  <= K_RD;
         cmos_q  <= 1'b0;
         dec_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (accept_o) begin
            kind_q <= op_kind;
            cmos_q <= cmos_sel;
            dec_q  <= dec_mode;
         end
      end
   end

   always_comb begin
      act_o  = (phase_q == PH_RD1) || (phase_q == PH_RD2) ||
               (phase_q == PH_STALL) || (phase_q == PH_WR);
      wr_o   = (phase_q == PH_WR) || ((phase_q == PH_STALL) && !cmos_q);
      done_o = (phase_q == PH_WR) || (phase_q == PH_RD2) || (phase_q == PH_NOP) ||
               ((phase_q == PH_RD1) && (kind_q != K_RMW) && !two_reads);
      irq_o  = done_o && act_o;
   end

   assign phase_o = phase_q;
   assign cmos_o  = cmos_q;

   // R4: the stall cycle is always followed by the final write
   assert_stall_then_write_R4: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_STALL) |=> (phase_q == PH_WR));

   // R11: no new first-read phase may start from a busy phase
   assert_busy_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
      (phase_q != PH_IDLE) |=> (phase_q != PH_RD1 && phase_q != PH_NOP));

   // R9: the interrupt sample point is a single cycle per operation
   assert_single_sample_R9: assert property (@(posedge clk) disable iff (rst)
      irq_o |=> !irq_o);
endmodule

// File: rtl/opmem_addr.sv
module opmem_addr #(
   parameter int AW        = 16,
   parameter int PAGE_BITS = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic          zp_sel,
   input  logic [AW-1:0] eff_addr,
   output logic [AW-1:0] addr_o
);
   localparam int HI_BITS = AW - PAGE_BITS;

   logic [AW-1:0] addr_q;
   logic          zp_q;

   if (PAGE_BITS < 1 || PAGE_BITS >= AW) begin : g_bad_page
      $error("opmem_addr: PAGE_BITS must lie in 1..AW-1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         zp_q   <= 1'b0;
      end else if (load) begin
         addr_q <= eff_addr;
         zp_q   <= zp_sel;
      end
   end

   for (genvar b = 0; b < AW; b++) begin : g_bit
      if (b < PAGE_BITS) begin : g_low
         assign addr_o[b] = addr_q[b];
      end else begin : g_high
         assign addr_o[b] = addr_q[b] && !zp_q;
      end
   end

   // R8: a zero-page access keeps the upper address bits clear
   assert_zp_upper_R8: assert property (@(posedge clk) disable iff (rst)
      zp_q |-> (addr_o[AW-1:PAGE_BITS] == {HI_BITS{1'b0}}));
endmodule

// File: rtl/opmem_data.sv
module opmem_data
   import opmem_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  phase_t        phase,
   input  logic          wr,
   input  logic [DW-1:0] bus_din,
   input  logic [DW-1:0] mod_data,
   output logic [DW-1:0] dout_o
);
   logic [DW-1:0] cap_q;

   if (DW < 1) begin : g_bad_width
      $error("opmem_data: DW must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)                  cap_q <= '0;
      else if (phase == PH_RD1) cap_q <= bus_din;
   end

   always_comb begin
      if (!wr)                  dout_o = '0;
      else if (phase == PH_WR)  dout_o = mod_data;
      else                      dout_o = cap_q;
   end

   // R2: nothing is driven on the data lines outside a write
   assert_quiet_dout_R2: assert property (@(posedge clk) disable iff (rst)
      !wr |-> (dout_o == '0));
endmodule

// File: rtl/opmem_seq.sv
module opmem_seq
   import opmem_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int PAGE_BITS = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [1:0]    op_kind,
   input  logic          zp_sel,
   input  logic          cmos_sel,
   input  logic          dec_mode,
   input  logic [AW-1:0] eff_addr,
   input  logic [DW-1:0] mod_data,
   input  logic [DW-1:0] bus_din,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_dout,
   output logic          bus_act,
   output logic          bus_wr,
   output logic          done,
   output logic          irq_sample
);
   phase_t phase;
   logic   accept;
   logic   cmos_q;

   opmem_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .op_kind  (op_kind),
      .cmos_sel (cmos_sel),
      .dec_mode (dec_mode),
      .phase_o  (phase),
      .accept_o (accept),
      .cmos_o   (cmos_q),
      .act_o    (bus_act),
      .wr_o     (bus_wr),
      .done_o   (done),
      .irq_o    (irq_sample)
   );

   opmem_addr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_addr (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .zp_sel   (zp_sel),
      .eff_addr (eff_addr),
      .addr_o   (bus_addr)
   );

   opmem_data #(.DW(DW)) u_data (
      .clk      (clk),
      .rst      (rst),
      .phase    (phase),
      .wr       (bus_wr),
      .bus_din  (bus_din),
      .mod_data (mod_data),
      .dout_o   (bus_dout)
   );

   // R5: a write that is not the last cycle returns the byte read just before
   assert_writeback_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !done) |-> (bus_dout == $past(bus_din)));

   // R6: with the CMOS model latched, no write happens before the done cycle
   assert_cmos_stall_read_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_act && !done && cmos_q) |-> !bus_wr);

   // R11: after the done cycle the bus goes quiet for at least one cycle
   assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (rst)
      done |=> (!bus_act && !done));
endmodule

// File: tb/sim_opmem_seq.sv
module sim_opmem_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [1:0]  op_kind = 2'd0;
   logic        zp_sel = 1'b0, cmos_sel = 1'b0, dec_mode = 1'b0;
   logic [15:0] eff_addr = 16'h0;
   logic [7:0]  mod_data = 8'h0, bus_din = 8'h0;
   logic [15:0] bus_addr;
   logic [7:0]  bus_dout;
   logic        bus_act, bus_wr, done, irq_sample;

   always #10 clk = ~clk;

   opmem_seq u0 (
      .clk(clk), .rst(rst), .start(start), .op_kind(op_kind), .zp_sel(zp_sel),
      .cmos_sel(cmos_sel), .dec_mode(dec_mode), .eff_addr(eff_addr),
      .mod_data(mod_data), .bus_din(bus_din), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_act(bus_act), .bus_wr(bus_wr), .done(done),
      .irq_sample(irq_sample)
   );

   // expected cycle: dsel 0 = zero, 1 = live mod_data, 2 = captured read byte
   typedef struct {
      bit          act, wr, dn, cap;
      int          dsel;
      logic [15:0] addr;
      string       tag;
   } cyc_t;

   cyc_t  q[$];
   int    vectors = 0, miscompares = 0;
   logic [7:0] cap_exp = 8'h0;

   function automatic cyc_t mk(bit act, bit wr, bit dn, bit cap, int dsel,
                               logic [15:0] a, string tag);
      cyc_t c;
      c.act = act; c.wr = wr; c.dn = dn; c.cap = cap; c.dsel = dsel;
      c.addr = a; c.tag = tag;
      return c;
   endfunction

   task automatic chk(string tag, string what, logic [15:0] act_v, logic [15:0] exp_v);
      vectors++;
      if (act_v !== exp_v) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
      end
   endtask

   // queue the cycles an accepted operation must produce
   task automatic plan_op(logic [1:0] k, bit z, bit cm, bit dm, logic [15:0] a);
      logic [15:0] ea = z ? {8'h00, a[7:0]} : a;
      string ta = z ? "R8" : "R2";
      if (k == 2'd3 && cm) begin
         q.push_back(mk(0, 0, 1, 0, 0, 16'h0, "R10"));
      end else if (k == 2'd1) begin
         q.push_back(mk(1, 1, 1, 0, 1, ea, z ? "R8" : "R3 R12"));
      end else if (k == 2'd2) begin
         q.push_back(mk(1, 0, 0, 1, 0, ea, z ? "R8" : "R4"));
         if (cm) q.push_back(mk(1, 0, 0, 0, 0, ea, "R6"));
         else    q.push_back(mk(1, 1, 0, 0, 2, ea, "R5"));
         q.push_back(mk(1, 1, 1, 0, 1, ea, "R4 R12"));
      end else if (cm && dm) begin
         q.push_back(mk(1, 0, 0, 1, 0, ea, "R7"));
         q.push_back(mk(1, 0, 1, 0, 0, ea, "R7"));
      end else begin
         q.push_back(mk(1, 0, 1, 1, 0, ea, (k == 2'd3) ? "R10" : ta));
      end
   endtask

   task automatic compare(const ref cyc_t e);
      logic [7:0] dexp;
      dexp = (e.dsel == 1) ? mod_data : (e.dsel == 2) ? cap_exp : 8'h00;
      chk(e.tag, "bus_act", {15'h0, bus_act}, {15'h0, e.act});
      chk(e.tag, "bus_wr", {15'h0, bus_wr}, {15'h0, e.wr});
      chk(e.tag, "done", {15'h0, done}, {15'h0, e.dn});
      chk({e.tag, " R9"}, "irq_sample", {15'h0, irq_sample}, {15'h0, e.dn && e.act});
      chk(e.tag, "bus_dout", {8'h0, bus_dout}, {8'h0, dexp});
      if (e.act) chk(e.tag, "bus_addr", bus_addr, e.addr);
   endtask

   int directed = 0;
   bit finished = 0;

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            if (!finished) begin
               miscompares++;
               $display("FAIL watchdog: actual timeout expected completion");
            end
         end
         begin
            cyc_t idle_c;
            // R1: reset state
            repeat (3) begin
               @(negedge clk);
               idle_c = mk(0, 0, 0, 0, 0, 16'h0, "R1");
               compare(idle_c);
            end
            rst = 1'b0;
            for (int cyc = 0; cyc < 4000; cyc++) begin
               cyc_t e;
               bit   was_idle;
               @(negedge clk);
               was_idle = (q.size() == 0);
               if (was_idle) e = mk(0, 0, 0, 0, 0, 16'h0, (cyc < 2) ? "R1" : "R11");
               else          e = q.pop_front();
               compare(e);
               // new random bus and modified data each cycle
               bus_din  = 8'($urandom);
               mod_data = 8'($urandom);
               if (e.cap) cap_exp = bus_din;
               // scramble latched inputs every cycle (R12)
               op_kind  = 2'($urandom);
               zp_sel   = 1'($urandom);
               cmos_sel = 1'($urandom);
               dec_mode = 1'($urandom);
               eff_addr = 16'($urandom);
               start    = 1'b0;
               if (was_idle && directed < 32) begin
                  {op_kind, cmos_sel, dec_mode, zp_sel} = 5'(directed);
                  directed++;
                  start = 1'b1;
               end else if (directed >= 32) begin
                  start = 1'($urandom); // stray starts while busy test R11
               end
               if (start && was_idle)
                  plan_op(op_kind, zp_sel, cmos_sel, dec_mode, eff_addr);
            end
            finished = 1;
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule